// File: doc/BRIEF.md
# Interrupt Status Register with Channel-Busy and Antenna-Slot Events

This block holds an eight-bit interrupt status word for an embedded controller. Each bit latches a one-cycle event and stays set until something clears it. Software clears a bit by writing a one to its position. A separate enable word, one bit per status bit, decides whether a pending bit drives the controller interrupt line.

The two upper bits have their own event logic inside the block. Bit 7 latches whenever the registered channel-busy indication changes level, whether it rises or falls. Bit 6 latches once per antenna diversity slot. The slot comes from a down-counter that reloads from a programmable length. A receive-reset control also clears bit 6 in hardware. The six lower bits latch generic one-cycle event pulses from neighbouring logic.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status_o, mask_o and irq_o are all zero.
- R2: A cycle with stat_wr_i high clears every status bit whose stat_wdata_i bit is 1. Bits written 0 keep their value.
- R3: If an event sets a bit in the same cycle that a write-one-clear targets it, the bit ends up set.
- R4: A change of chbusy_i in either direction sets status bit 7. The bit is visible after the second rising clock edge that follows the change, because the input is first registered and then compared with its previous sample.
- R5: With slot_en_i high and slot_len_i = L (L >= 1), status bit 6 first sets after the (L+1)-th rising edge after enabling, and again every L cycles after that.
- R6: While slot_en_i is low, the slot timer produces no events and status bit 6 never sets from it.
- R7: rx_reset_i high at an edge clears status bit 6. It takes priority over a slot event in the same cycle. The other bits are not affected.
- R8: A pulse on gen_evt_i[k] (k = 0..5) sets status bit k at the next edge.
- R9: A status bit whose mask bit is 0 still sets, but it does not drive irq_o.
- R10: irq_o is 1 exactly when some bit is set in both status_o and mask_o. mask_o loads mask_wdata_i at an edge where mask_wr_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chbusy_i | input | 1 | Channel-busy indication |
| slot_en_i | input | 1 | Enables the antenna slot timer |
| slot_len_i | input | 8 | Slot length in clock cycles |
| rx_reset_i | input | 1 | Receive-reset control; clears status bit 6 |
| gen_evt_i | input | 6 | Generic event pulses for status bits 5..0 |
| stat_wr_i | input | 1 | Write strobe for write-one-clear |
| stat_wdata_i | input | 8 | Bits to clear (1 = clear) |
| mask_wr_i | input | 1 | Write strobe for the interrupt enable word |
| mask_wdata_i | input | 8 | New interrupt enable word |
| status_o | output | 8 | Interrupt status bits |
| mask_o | output | 8 | Interrupt enable bits |
| irq_o | output | 1 | Controller interrupt request |

## Verification
A wrong status bit shows on status_o one edge after its cause and reaches irq_o in the same cycle if that bit is enabled. A stale channel-busy sample shows up as a missing or extra bit-7 event two edges after an input change. A miscounting slot counter moves the bit-6 event off the exact edge that follows from slot_len_i. The bench compares the first event against its edge and then each following period, so an off-by-one error shows within one slot.

// File: rtl/irq_status_pkg.sv
// Package: widths and bit positions shared by the interrupt status unit.
// Assumes two dedicated event sources sit above the generic ones.
package irq_status_pkg;
    localparam int GEN_EVENTS = 6;
    localparam int STAT_W     = GEN_EVENTS + 2;
    localparam int BIT_CHB    = STAT_W - 1;   // channel-busy change
    localparam int BIT_ANT    = STAT_W - 2;   // antenna slot end
    localparam int SLOT_W     = 8;
endpackage

// File: rtl/chbusy_change_det.sv
// Module: registers the channel-busy input and flags any level change
// between two consecutive samples. Assumes chbusy_i is synchronous to clk.
module chbusy_change_det (
    input  logic clk,
    input  logic rst_n,
    input  logic chbusy_i,
    output logic change_o
);
    logic smp_q;
    logic prev_q;

    // Sample the input and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            smp_q  <= chbusy_i;
            prev_q <= smp_q;
        end
    end

    // A change is a mismatch between the two samples.
    always_comb change_o = smp_q ^ prev_q;

    AST_CHB_CHANGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (chbusy_i != smp_q) |=> change_o); // R4
endmodule

// File: rtl/antenna_slot_timer.sv
// Module: down-counter that reloads from the programmed slot length and
// emits one registered pulse per slot while enabled. Length 0 acts as 1.
module antenna_slot_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] len_i,
    output logic         pulse_o
);
    logic [W-1:0] cnt_q;
    logic         pulse_q;

    // Count down while enabled; preload while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (!en_i) begin
            cnt_q   <= len_i;
            pulse_q <= 1'b0;
        end else if (cnt_q <= W'(1)) begin
            cnt_q   <= len_i;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - W'(1);
            pulse_q <= 1'b0;
        end
    end

    always_comb pulse_o = pulse_q;

    AST_SLOT_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pulse_o); // R6
endmodule

// File: rtl/irq_status_reg.sv
// Module: bank of sticky status bits with event set, write-one-clear and a
// per-bit hardware clear. Priority per bit: hardware clear, then set, then W1C.
module irq_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] hwclr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Update one status bit by its fixed priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[b] <= 1'b0;
            else if (hwclr_i[b])
                stat_q[b] <= 1'b0;
            else if (set_i[b])
                stat_q[b] <= 1'b1;
            else if (wr_i && wdata_i[b])
                stat_q[b] <= 1'b0;
        end
    end

    always_comb stat_o = stat_q;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((stat_q & $past(wdata_i & ~set_i)) == '0)); // R2
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q | set_i)) == '0)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_i & ~hwclr_i) & ~stat_q) == '0)); // R3
    AST_HWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(hwclr_i)) == '0)); // R7
endmodule

// File: rtl/irq_status_unit.sv
// Module: top of the interrupt status unit. Wires the channel-busy change
// detector, slot timer and status bank together, and holds the enable word
// and the interrupt output. Assumes all inputs are synchronous to clk.
module irq_status_unit
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chbusy_i,
    input  logic              slot_en_i,
    input  logic [SLOT_W-1:0] slot_len_i,
    input  logic              rx_reset_i,
    input  logic [GEN_EVENTS-1:0] gen_evt_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    input  logic              mask_wr_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);
    logic              chb_change;
    logic              slot_pulse;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] hwclr_vec;
    logic [STAT_W-1:0] mask_q;

    chbusy_change_det u_chb (
        .clk      (clk),
        .rst_n    (rst_n),
        .chbusy_i (chbusy_i),
        .change_o (chb_change)
    );

    antenna_slot_timer #(.W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (slot_en_i),
        .len_i   (slot_len_i),
        .pulse_o (slot_pulse)
    );

    // Collect event sets and hardware clears per status bit.
    always_comb begin
        set_vec            = '0;
        set_vec[GEN_EVENTS-1:0] = gen_evt_i;
        set_vec[BIT_ANT]   = slot_pulse;
        set_vec[BIT_CHB]   = chb_change;
        hwclr_vec          = '0;
        hwclr_vec[BIT_ANT] = rx_reset_i;
    end

    irq_status_reg #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .hwclr_i (hwclr_vec),
        .wr_i    (stat_wr_i),
        .wdata_i (stat_wdata_i),
        .stat_o  (status_o)
    );

    // Hold the interrupt enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr_i)
            mask_q <= mask_wdata_i;
    end

    // Raise the interrupt when any enabled bit is pending.
    always_comb begin
        mask_o = mask_q;
        irq_o  = |(status_o & mask_q);
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o); // R9
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != '0)); // R10
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(!rst_n) |-> (status_o == '0 && mask_o == '0)); // R1
endmodule

// File: tb/tb_irq_status_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_irq_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chbusy = 1'b0;
    logic       slot_en = 1'b0;
    logic [7:0] slot_len = 8'd5;
    logic       rx_reset = 1'b0;
    logic [5:0] gen_evt = '0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] status;
    logic [7:0] mask;
    logic       irq;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .chbusy_i(chbusy), .slot_en_i(slot_en),
        .slot_len_i(slot_len), .rx_reset_i(rx_reset), .gen_evt_i(gen_evt),
        .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .status_o(status), .mask_o(mask), .irq_o(irq)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic w1c(input logic [7:0] d);
        stat_wr = 1'b1; stat_wdata = d; tick();
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic t_reset();
        tick(3); rst_n = 1'b1; tick();
        check("R1 status", status, 8'h00);
        check("R1 mask", mask, 8'h00);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_w1c();
        gen_evt = 6'h0F; tick(); gen_evt = '0;
        check("R8 gen set", status, 8'h0F);
        w1c(8'h05);
        check("R2 partial clear", status, 8'h0A);
        w1c(8'h00);
        check("R2 zero write", status, 8'h0A);
        w1c(8'hFF);
        check("R2 full clear", status, 8'h00);
    endtask

    task automatic t_set_wins();
        gen_evt = 6'h01; stat_wr = 1'b1; stat_wdata = 8'h01; tick();
        gen_evt = '0; stat_wr = 1'b0; stat_wdata = '0;
        check("R3 set beats clear", status, 8'h01);
        w1c(8'h01);
        check("R2 cleared after", status, 8'h00);
    endtask

    task automatic t_chbusy();
        chbusy = 1'b1; tick();
        check("R4 rise edge1", status[7], 1'b0);
        tick();
        check("R4 rise edge2", status[7], 1'b1);
        w1c(8'h80);
        check("R4 cleared", status[7], 1'b0);
        tick(3);
        check("R4 steady level no event", status[7], 1'b0);
        chbusy = 1'b0; tick(2);
        check("R4 fall", status, 8'h80);
        w1c(8'h80);
    endtask

    task automatic t_slot();
        slot_len = 8'd5; tick(2);
        slot_en = 1'b1; tick(5);
        check("R5 before first slot", status[6], 1'b0);
        tick();
        check("R5 first slot", status[6], 1'b1);
        w1c(8'h40);
        tick(3);
        check("R5 mid period", status[6], 1'b0);
        tick();
        check("R5 second slot", status[6], 1'b1);
        w1c(8'h40);
        tick(3);
        gen_evt = 6'h02; rx_reset = 1'b1; tick();
        rx_reset = 1'b0; gen_evt = '0;
        check("R7 clear beats slot", status, 8'h02);
        tick(5);
        check("R5 third-after", status[6], 1'b1);
        rx_reset = 1'b1; tick(); rx_reset = 1'b0;
        check("R7 rx reset clears", status, 8'h02);
        w1c(8'h02);
        slot_en = 1'b0; tick(12);
        check("R6 disabled quiet", status, 8'h00);
    endtask

    task automatic t_mask();
        gen_evt = 6'h10; tick(); gen_evt = '0;
        check("R9 sets while masked", status, 8'h10);
        check("R9 no irq", irq, 1'b0);
        mask_wr = 1'b1; mask_wdata = 8'h10; tick(); mask_wr = 1'b0;
        check("R10 mask load", mask, 8'h10);
        check("R10 irq high", irq, 1'b1);
        mask_wr = 1'b1; mask_wdata = 8'hEF; tick(); mask_wr = 1'b0;
        check("R10 other bits", irq, 1'b0);
        w1c(8'h10);
        gen_evt = 6'h08; tick(); gen_evt = '0;
        check("R10 irq follows", irq, 1'b1);
        w1c(8'h08);
        check("R10 irq drops", irq, 1'b0);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_w1c();
        t_set_wins();
        t_chbusy();
        t_slot();
        t_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule